// File: doc/BRIEF.md
# Deflection Controller Serial Control Slave

This block is the two-wire serial control port of a display deflection controller. It runs on a fast system clock and samples the SCL and SDA lines as ordinary inputs. Each line passes through a synchronizer and a hold-time filter, so short spikes never reach the protocol logic. A bus master loads a bank of byte-wide adjustment registers and a set of single-bit on/off controls through this port. Write bursts auto-increment through the bank, so one transfer can reload the whole set.

In a read transfer the slave returns one status byte, whatever subaddress was used before. The byte carries the horizontal and vertical sync-lock flags and a sticky protection latch. The latch is set by a protection trip input. It stays set until the master writes a clear command, or until the active-low supply reset returns every register to its default.

The protocol engine has eight states:
- `ST_IDLE`: waiting for a start.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_WR_BYTE`: shifting in a subaddress or data byte.
- `ST_WR_ACK`: acknowledging a written byte.
- `ST_RD_BYTE`: driving the status bits.
- `ST_RD_ACK`: the master's acknowledge slot.
- `ST_IGNORE`: off the bus until the next start or stop.

The transitions are:
- A start condition moves any state to `ST_ADDR`.
- A stop condition moves any state to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on a matching address, or to `ST_IGNORE` otherwise, on the SCL fall after the eighth bit.
- `ST_ADDR_ACK` goes to `ST_RD_BYTE` or `ST_WR_BYTE`, chosen by the direction bit.
- `ST_WR_BYTE` and `ST_WR_ACK` alternate.
- `ST_RD_BYTE` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` goes to `ST_IGNORE`.

Top module: `dfl_i2c_ctrl`

## Requirements
- R1: The slave acknowledges the address byte 0x8C (write) and 0x8D (read), i.e. 7-bit address 0x46. It does not acknowledge any other address, nor any byte that follows it, until the next start condition. A repeated start with a matching address is then served normally.
- R2: In a write, the first byte after the address is the subaddress and the next byte is data. Every byte is taken MSB first and acknowledged by SDA held low during the ninth clock. Subaddress i (0..21) loads adjustment register i, which appears on `adj_bus[8*i+7:8*i]`.
- R3: Each further data byte without a stop or start goes to the next subaddress. After subaddress 24 (or any higher one) the next subaddress is 0.
- R4: Data written to subaddresses 25..255 is acknowledged but changes no register and no output.
- R5: A read returns one byte with bit 0 = horizontal lock, bit 1 = vertical lock, bit 2 = protection latch and bits 7:3 = 0. After that byte the slave leaves SDA released, so a further byte reads as 0xFF.
- R6: The slave pulls SDA low only in acknowledge slots of matched address and write bytes, and for zero bits of the reply byte. After a stop, `sda_pull_low` is 0. The block has no SCL output.
- R7: A pulse on SCL or SDA shorter than `FILT_CYCLES` system clocks (default 8) has no effect on the transfer.
- R8: While `pwr_rst_n` is low, every adjustment register reads 0x80, all controls read 0, the protection latch is clear and the bus engine is idle.
- R9: The protection latch sets while `prot_trip_in` is high and stays set after it falls. Writing a byte with bit 0 = 1 to subaddress 24 clears it. A trip that is active at the same time as the clear wins.
- R10: Subaddress 22 bits 7:0 load `ctl_bits[7:0]`, and subaddress 23 bits 5:0 load `ctl_bits[13:8]`. Bits 7:6 of subaddress 23 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pwr_rst_n | input | 1 | Asynchronous active-low supply reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull_low | output | 1 | 1 = pull SDA low (open-drain driver enable) |
| hlock_in | input | 1 | Horizontal sync lock flag |
| vlock_in | input | 1 | Vertical sync lock flag |
| prot_trip_in | input | 1 | Protection trip, sets the sticky latch |
| adj_bus | output | 176 | 22 adjustment registers, 8 bits each |
| ctl_bits | output | 14 | On/off control bits |

## Verification
Writes are tried in several forms:
- A single byte with a bit-asymmetric value separates MSB-first from LSB-first shifting.
- A burst across the adjustment and control boundary, through the clear command and on to subaddress 0, checks increment order and wrap.
- A burst starting at an unimplemented subaddress separates "discard and wrap" from "store".
- A foreign address followed by a repeated start checks that the engine stays silent and then recovers.

Reads are run with different lock and trip patterns, including trip and clear together, to tell each status bit apart and to show that the latch is sticky. A write whose bits carry SCL and SDA spikes shorter than the filter window must land exactly like a clean write.

// File: rtl/dfl_i2c_pkg.sv
package dfl_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } i2c_state_t;

    localparam int BYTE_W  = 8;
    localparam int BCNT_W  = 4;

endpackage

// File: rtl/dfl_line_filter.sv
module dfl_line_filter #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic sync_o,
    output logic level_o
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic             meta_q;
    logic             sync_q;
    logic [CNT_W-1:0] run_q;

    // Two-flop synchronizer, then a new level is accepted only after it
    // has been seen for HOLD_CYCLES consecutive samples.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q  <= 1'b1;
            sync_q  <= 1'b1;
            level_o <= 1'b1;
            run_q   <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            if (sync_q == level_o) begin
                run_q <= '0;
            end else if (run_q == CNT_W'(HOLD_CYCLES - 1)) begin
                level_o <= sync_q;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/dfl_i2c_engine.sv
module dfl_i2c_engine
    import dfl_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h46
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic [BYTE_W-1:0] status_byte,
    output logic              sda_pull_low,
    output logic              wr_sub_stb,
    output logic              wr_dat_stb,
    output logic [BYTE_W-1:0] wr_byte,
    output i2c_state_t        state_o,
    output logic              stop_o
);

    i2c_state_t        state_q, state_d;
    logic              scl_q, sda_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [BCNT_W-1:0] bit_cnt_q;
    logic              sub_phase_q;

    logic scl_rise, scl_fall, start_det, stop_det, addr_hit, byte_full;

    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;
    assign start_det = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    assign addr_hit  = (shreg_q[7:1] == DEV_ADDR);
    assign byte_full = (bit_cnt_q == BCNT_W'(BYTE_W));

    // Filtered line history for edge and condition detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_IGNORE:   state_d = ST_IGNORE;
                ST_ADDR:     if (scl_fall && byte_full)
                                 state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)
                                 state_d = shreg_q[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (scl_fall && byte_full) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && byte_full) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_d = ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs: shifting, bit counting, SDA drive, strobes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q      <= '0;
            bit_cnt_q    <= '0;
            sda_pull_low <= 1'b0;
            sub_phase_q  <= 1'b1;
            wr_sub_stb   <= 1'b0;
            wr_dat_stb   <= 1'b0;
            wr_byte      <= '0;
        end else begin
            wr_sub_stb <= 1'b0;
            wr_dat_stb <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt_q    <= '0;
                sda_pull_low <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise && !byte_full) begin
                            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_f};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end else if (scl_fall && byte_full) begin
                            bit_cnt_q <= '0;
                            if (state_q == ST_ADDR) begin
                                sda_pull_low <= addr_hit;
                            end else begin
                                sda_pull_low <= 1'b1;
                                wr_byte      <= shreg_q;
                                wr_sub_stb   <= sub_phase_q;
                                wr_dat_stb   <= ~sub_phase_q;
                                sub_phase_q  <= 1'b0;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            sub_phase_q <= 1'b1;
                            bit_cnt_q   <= '0;
                            if (shreg_q[0]) begin
                                shreg_q      <= status_byte;
                                sda_pull_low <= ~status_byte[BYTE_W-1];
                            end else begin
                                sda_pull_low <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) sda_pull_low <= 1'b0;
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise) begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end else if (scl_fall) begin
                            if (byte_full) begin
                                sda_pull_low <= 1'b0;
                            end else begin
                                shreg_q      <= {shreg_q[BYTE_W-2:0], 1'b0};
                                sda_pull_low <= ~shreg_q[BYTE_W-2];
                            end
                        end
                    end
                    ST_IDLE, ST_RD_ACK, ST_IGNORE: begin
                        sda_pull_low <= 1'b0;
                    end
                    default: sda_pull_low <= 1'b0;
                endcase
            end
        end
    end

    assign state_o = state_q;
    assign stop_o  = stop_det;

endmodule

// File: rtl/dfl_ctrl_bank.sv
module dfl_ctrl_bank
    import dfl_i2c_pkg::*;
#(
    parameter int               NUM_ADJ     = 22,
    parameter int               NUM_CTL     = 14,
    parameter logic [BYTE_W-1:0] ADJ_DEFAULT = 8'h80
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_sub_stb,
    input  logic                      wr_dat_stb,
    input  logic [BYTE_W-1:0]         wr_byte,
    input  logic                      hlock_in,
    input  logic                      vlock_in,
    input  logic                      prot_trip_in,
    output logic [NUM_ADJ*BYTE_W-1:0] adj_bus,
    output logic [NUM_CTL-1:0]        ctl_bits,
    output logic [BYTE_W-1:0]         status_byte,
    output logic                      prot_latch_o,
    output logic                      trip_sync_o,
    output logic                      clr_stb_o
);

    localparam int CTL_REGS = (NUM_CTL + BYTE_W - 1) / BYTE_W;
    localparam int CLR_SUB  = NUM_ADJ + CTL_REGS;
    localparam int LAST_SUB = CLR_SUB;

    logic [BYTE_W-1:0] sub_ptr_q;
    logic [2:0]        in_meta_q, in_sync_q;
    logic              prot_latch_q;
    logic              clr_stb;

    // Subaddress counter with wrap past the last implemented address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_ptr_q <= '0;
        end else if (wr_sub_stb) begin
            sub_ptr_q <= wr_byte;
        end else if (wr_dat_stb) begin
            sub_ptr_q <= (sub_ptr_q >= BYTE_W'(LAST_SUB)) ? '0 : sub_ptr_q + 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_ADJ; i++) begin : g_adj
        logic [BYTE_W-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val_q <= ADJ_DEFAULT;
            else if (wr_dat_stb && sub_ptr_q == BYTE_W'(i))
                val_q <= wr_byte;
        end
        assign adj_bus[i*BYTE_W +: BYTE_W] = val_q;
    end

    for (genvar b = 0; b < NUM_CTL; b++) begin : g_ctl
        localparam int REG_IDX = NUM_ADJ + b / BYTE_W;
        localparam int POS     = b % BYTE_W;
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (wr_dat_stb && sub_ptr_q == BYTE_W'(REG_IDX))
                bit_q <= wr_byte[POS];
        end
        assign ctl_bits[b] = bit_q;
    end

    // Status input synchronizers: {trip, vlock, hlock}.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_meta_q <= '0;
            in_sync_q <= '0;
        end else begin
            in_meta_q <= {prot_trip_in, vlock_in, hlock_in};
            in_sync_q <= in_meta_q;
        end
    end

    assign clr_stb = wr_dat_stb && (sub_ptr_q == BYTE_W'(CLR_SUB)) && wr_byte[0];

    // Sticky protection latch, trip dominates clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             prot_latch_q <= 1'b0;
        else if (in_sync_q[2])  prot_latch_q <= 1'b1;
        else if (clr_stb)       prot_latch_q <= 1'b0;
    end

    assign status_byte  = {5'b0, prot_latch_q, in_sync_q[1], in_sync_q[0]};
    assign prot_latch_o = prot_latch_q;
    assign trip_sync_o  = in_sync_q[2];
    assign clr_stb_o    = clr_stb;

endmodule

// File: rtl/dfl_i2c_ctrl.sv
module dfl_i2c_ctrl
    import dfl_i2c_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR    = 7'h46,
    parameter int                FILT_CYCLES = 8,
    parameter int                NUM_ADJ     = 22,
    parameter int                NUM_CTL     = 14,
    parameter logic [BYTE_W-1:0] ADJ_DEFAULT = 8'h80
) (
    input  logic                      clk,
    input  logic                      pwr_rst_n,
    input  logic                      scl_in,
    input  logic                      sda_in,
    output logic                      sda_pull_low,
    input  logic                      hlock_in,
    input  logic                      vlock_in,
    input  logic                      prot_trip_in,
    output logic [NUM_ADJ*BYTE_W-1:0] adj_bus,
    output logic [NUM_CTL-1:0]        ctl_bits
);

    logic              scl_f, sda_f, scl_s, sda_s;
    logic              wr_sub_stb, wr_dat_stb;
    logic [BYTE_W-1:0] wr_byte, status_byte;
    i2c_state_t        eng_state;
    logic              stop_evt, prot_latch, trip_s, clr_stb;

    dfl_line_filter #(.HOLD_CYCLES(FILT_CYCLES)) u_scl_filt (
        .clk     (clk),
        .rst_n   (pwr_rst_n),
        .pin_i   (scl_in),
        .sync_o  (scl_s),
        .level_o (scl_f)
    );

    dfl_line_filter #(.HOLD_CYCLES(FILT_CYCLES)) u_sda_filt (
        .clk     (clk),
        .rst_n   (pwr_rst_n),
        .pin_i   (sda_in),
        .sync_o  (sda_s),
        .level_o (sda_f)
    );

    dfl_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
        .clk          (clk),
        .rst_n        (pwr_rst_n),
        .scl_f        (scl_f),
        .sda_f        (sda_f),
        .status_byte  (status_byte),
        .sda_pull_low (sda_pull_low),
        .wr_sub_stb   (wr_sub_stb),
        .wr_dat_stb   (wr_dat_stb),
        .wr_byte      (wr_byte),
        .state_o      (eng_state),
        .stop_o       (stop_evt)
    );

    dfl_ctrl_bank #(
        .NUM_ADJ     (NUM_ADJ),
        .NUM_CTL     (NUM_CTL),
        .ADJ_DEFAULT (ADJ_DEFAULT)
    ) u_bank (
        .clk          (clk),
        .rst_n        (pwr_rst_n),
        .wr_sub_stb   (wr_sub_stb),
        .wr_dat_stb   (wr_dat_stb),
        .wr_byte      (wr_byte),
        .hlock_in     (hlock_in),
        .vlock_in     (vlock_in),
        .prot_trip_in (prot_trip_in),
        .adj_bus      (adj_bus),
        .ctl_bits     (ctl_bits),
        .status_byte  (status_byte),
        .prot_latch_o (prot_latch),
        .trip_sync_o  (trip_s),
        .clr_stb_o    (clr_stb)
    );

endmodule

// File: rtl/dfl_i2c_ctrl_chk.sv
module dfl_i2c_ctrl_chk
    import dfl_i2c_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sda_pull_low,
    input i2c_state_t state,
    input logic       stop_evt,
    input logic       scl_f,
    input logic       scl_s,
    input logic       sda_f,
    input logic       sda_s,
    input logic       prot_latch,
    input logic       trip_s,
    input logic       clr_stb
);

    // R6: SDA is only pulled in acknowledge slots or reply bits.
    a_r6_drive_slots: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_low |-> (state == ST_ADDR_ACK || state == ST_WR_ACK || state == ST_RD_BYTE));

    // R6: a stop releases the line and idles the engine.
    a_r6_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!sda_pull_low && state == ST_IDLE));

    // R1: after a foreign address the slave stays off the line.
    a_r1_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_pull_low);

    // R7: a filtered edge only ever adopts the synchronized line level.
    a_r7_scl_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(scl_f) |-> (scl_f == $past(scl_s)));

    a_r7_sda_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_f) |-> (sda_f == $past(sda_s)));

    // R9: latch is set by a trip and held until a clear command.
    a_r9_trip_sets: assert property (@(posedge clk) disable iff (!rst_n)
        trip_s |=> prot_latch);

    a_r9_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_latch && !clr_stb) |=> prot_latch);

endmodule

bind dfl_i2c_ctrl dfl_i2c_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (pwr_rst_n),
    .sda_pull_low (sda_pull_low),
    .state        (eng_state),
    .stop_evt     (stop_evt),
    .scl_f        (scl_f),
    .scl_s        (scl_s),
    .sda_f        (sda_f),
    .sda_s        (sda_s),
    .prot_latch   (prot_latch),
    .trip_s       (trip_s),
    .clr_stb      (clr_stb)
);

// File: tb/dfl_i2c_ctrl_tb.sv
`timescale 1ns/1ps
module dfl_i2c_ctrl_tb;

    localparam int NADJ = 22;
    localparam int NCTL = 14;
    localparam int Q    = 25;

    logic clk = 1'b0;
    logic pwr_rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic hlock = 1'b0, vlock = 1'b0, trip = 1'b0;
    logic sda_pull_low;
    logic [NADJ*8-1:0] adj_bus;
    logic [NCTL-1:0]   ctl_bits;
    wire  sda_bus = sda_m & ~sda_pull_low;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [7:0]  m_adj [NADJ];
    logic [13:0] m_ctl;

    always #5 clk = ~clk;

    dfl_i2c_ctrl u_dut (
        .clk          (clk),
        .pwr_rst_n    (pwr_rst_n),
        .scl_in       (scl_m),
        .sda_in       (sda_bus),
        .sda_pull_low (sda_pull_low),
        .hlock_in     (hlock),
        .vlock_in     (vlock),
        .prot_trip_in (trip),
        .adj_bus      (adj_bus),
        .ctl_bits     (ctl_bits)
    );

    task automatic chk(input string req, input logic [NADJ*8-1:0] act, input logic [NADJ*8-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NADJ*8-1:0] model_flat();
        logic [NADJ*8-1:0] v;
        for (int i = 0; i < NADJ; i++) v[i*8 +: 8] = m_adj[i];
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NADJ; i++) m_adj[i] = 8'h80;
        m_ctl = '0;
    endtask

    task automatic model_write(input logic [7:0] sub, input logic [7:0] d[8], input int n);
        int p = sub;
        for (int k = 0; k < n; k++) begin
            if (p < NADJ)       m_adj[p] = d[k];
            else if (p == 22)   m_ctl[7:0] = d[k];
            else if (p == 23)   m_ctl[13:8] = d[k][5:0];
            p = (p >= 24) ? 0 : p + 1;
        end
    endtask

    task automatic bit_io(input logic b, output logic s);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(Q);
        s = sda_bus; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    // Bit with a short SCL spike in the low phase and, for ones, a short
    // SDA dip while SCL is high.
    task automatic glitch_bit(input logic b, output logic s);
        sda_m = b; wq(5);
        scl_m = 1'b1; wq(4); scl_m = 1'b0; wq(Q - 9);
        scl_m = 1'b1; wq(5);
        if (b) begin sda_m = 1'b0; wq(4); sda_m = 1'b1; wq(Q - 9); end
        else   wq(Q - 5);
        s = sda_bus; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic tx_byte(input logic [7:0] v, input bit glitchy, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            if (glitchy) glitch_bit(v[i], s);
            else         bit_io(v[i], s);
        end
        bit_io(1'b1, s);
        ack = ~s;
    endtask

    task automatic rx_byte(input logic m_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            v[i] = s;
        end
        bit_io(~m_ack, s);
    endtask

    task automatic wr_xfer(input logic [7:0] sub, input logic [7:0] d[8], input int n,
                           input bit glitchy, output logic all_ack);
        logic a;
        i2c_start();
        tx_byte(8'h8C, 1'b0, a); all_ack = a;
        tx_byte(sub, 1'b0, a);   all_ack &= a;
        for (int k = 0; k < n; k++) begin
            tx_byte(d[k], glitchy, a); all_ack &= a;
        end
        i2c_stop();
        model_write(sub, d, n);
    endtask

    task automatic rd_status(input bit two, output logic [7:0] v1, output logic [7:0] v2,
                             output logic a);
        i2c_start();
        tx_byte(8'h8D, 1'b0, a);
        rx_byte(two, v1);
        v2 = 8'hFF;
        if (two) rx_byte(1'b0, v2);
        i2c_stop();
    endtask

    task automatic supply_reset();
        pwr_rst_n = 1'b0; wq(4);
        pwr_rst_n = 1'b1; wq(4);
        model_reset();
    endtask

    task automatic t_reset_defaults();
        chk("R8 adjust defaults", adj_bus, model_flat());
        chk("R8 controls default", {162'b0, ctl_bits}, '0);
        chk("R6 idle release", {175'b0, sda_pull_low}, '0);
    endtask

    task automatic t_single_write();
        logic [7:0] d[8] = '{8'hC1, 0, 0, 0, 0, 0, 0, 0};
        logic a;
        wr_xfer(8'd5, d, 1, 1'b0, a);
        chk("R1 R2 acks on write", {175'b0, a}, 1);
        chk("R2 MSB-first store to subaddress 5", adj_bus, model_flat());
        chk("R6 released after stop", {175'b0, sda_pull_low}, '0);
    endtask

    task automatic t_burst_wrap();
        logic [7:0] d[8] = '{8'h14, 8'h15, 8'hA5, 8'hFF, 8'h00, 8'h77, 0, 0};
        logic a;
        wr_xfer(8'd20, d, 6, 1'b0, a);
        chk("R3 burst acks", {175'b0, a}, 1);
        chk("R3 auto-increment and wrap to 0", adj_bus, model_flat());
        chk("R10 control bit mapping", {162'b0, ctl_bits}, {162'b0, 14'h3FA5});
    endtask

    task automatic t_unimplemented();
        logic [7:0] d[8] = '{8'h11, 8'h22, 0, 0, 0, 0, 0, 0};
        logic a;
        wr_xfer(8'd40, d, 2, 1'b0, a);
        chk("R4 unimplemented acked", {175'b0, a}, 1);
        chk("R4 discard then wrap to 0", adj_bus, model_flat());
        chk("R4 controls untouched", {162'b0, ctl_bits}, {162'b0, m_ctl});
    endtask

    task automatic t_bad_address();
        logic a1, a2, a3, a4;
        i2c_start();
        tx_byte(8'h8E, 1'b0, a1);
        tx_byte(8'd1, 1'b0, a2);
        i2c_start();
        tx_byte(8'h8C, 1'b0, a3);
        tx_byte(8'd1, 1'b0, a4);
        tx_byte(8'h3C, 1'b0, a4);
        i2c_stop();
        m_adj[1] = 8'h3C;
        chk("R1 foreign address not acked", {175'b0, a1}, 0);
        chk("R1 byte after foreign address not acked", {175'b0, a2}, 0);
        chk("R1 repeated start served", {174'b0, a3, a4}, 2'b11);
        chk("R1 bank after recovery", adj_bus, model_flat());
    endtask

    task automatic t_status_read();
        logic [7:0] v1, v2;
        logic a;
        hlock = 1'b1; vlock = 1'b0; wq(5);
        rd_status(1'b1, v1, v2, a);
        chk("R5 read address acked", {175'b0, a}, 1);
        chk("R5 status hlock only", {168'b0, v1}, {168'b0, 8'h01});
        chk("R5 second byte released", {168'b0, v2}, {168'b0, 8'hFF});
        vlock = 1'b1; wq(5);
        rd_status(1'b0, v1, v2, a);
        chk("R5 status both locks", {168'b0, v1}, {168'b0, 8'h03});
    endtask

    task automatic t_latch();
        logic [7:0] v1, v2;
        logic [7:0] d[8] = '{8'h00, 0, 0, 0, 0, 0, 0, 0};
        logic a;
        vlock = 1'b0;
        trip = 1'b1; wq(6); trip = 1'b0; wq(20);
        rd_status(1'b0, v1, v2, a);
        chk("R9 latch set and sticky", {168'b0, v1}, {168'b0, 8'h05});
        wr_xfer(8'd24, d, 1, 1'b0, a);
        rd_status(1'b0, v1, v2, a);
        chk("R9 clear with bit0=0 has no effect", {168'b0, v1}, {168'b0, 8'h05});
        trip = 1'b1; wq(6);
        d[0] = 8'h01;
        wr_xfer(8'd24, d, 1, 1'b0, a);
        rd_status(1'b0, v1, v2, a);
        chk("R9 trip wins over clear", {168'b0, v1}, {168'b0, 8'h05});
        trip = 1'b0; wq(6);
        wr_xfer(8'd24, d, 1, 1'b0, a);
        rd_status(1'b0, v1, v2, a);
        chk("R9 clear command", {168'b0, v1}, {168'b0, 8'h01});
        trip = 1'b1; wq(6); trip = 1'b0; wq(6);
        supply_reset();
        t_reset_defaults();
        rd_status(1'b0, v1, v2, a);
        chk("R8 supply reset clears latch", {168'b0, v1}, {168'b0, 8'h01});
    endtask

    task automatic t_glitch();
        logic [7:0] d[8] = '{8'h96, 0, 0, 0, 0, 0, 0, 0};
        logic a;
        wr_xfer(8'd3, d, 1, 1'b1, a);
        chk("R7 glitched write acked", {175'b0, a}, 1);
        chk("R7 glitched write value", adj_bus, model_flat());
        chk("R7 released after glitched transfer", {175'b0, sda_pull_low}, '0);
    endtask

    initial begin
        model_reset();
        wq(4);
        pwr_rst_n = 1'b1;
        wq(20);
        t_reset_defaults();
        t_single_write();
        t_burst_wrap();
        t_unimplemented();
        t_bad_address();
        t_status_read();
        t_latch();
        t_glitch();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule